// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block turns one scalar operation, such as an integer add, into a loop over a vector length. It takes three operands: a destination and two sources. Each operand comes with its plain register number, its already-redirected register index and a flag that marks it as a vector. The block also takes a predicate mask, which was read for the destination before the loop, and the loop length. A single start strobe captures all of these inputs. From the next cycle on, the block walks the elements one per cycle. For each element it presents the operand indices and a valid strobe to a downstream ALU and register-file port. An element whose predicate bit is clear is skipped: it still uses its cycle, but no valid strobe is raised for it.

A vector operand steps its index by one for each element. A scalar operand keeps the same register throughout the loop. If the destination is scalar, the loop ends as soon as its first enabled element has been issued, because further writes to that one register would only overwrite it. The same operation code serves both scalar and vector use; no separate vector opcode is needed.

Top module: `pred_elem_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done` and `issueValid` are all 0.
- R2: A `start` seen while idle with a loop length of 1 or more captures every input. `busy` is 1 in the following cycle, which presents element 0. Element k is presented k cycles after element 0, and `issueElem` equals k. Input changes after the capture have no effect.
- R3: Each operand's base register is its redirected index when its vector flag is 1, and its plain register number when the flag is 0.
- R4: A vector operand presents base+k modulo 2^REG_W for element k. The offset counts skipped elements too. A scalar operand presents its base for every element.
- R5: `issueValid` is 1 for element k exactly when bit k of the captured predicate is 1. An element with a clear bit still takes one cycle.
- R6: `busy` stays 1 through the cycle of the last element. In the next cycle `busy` is 0 and `done` is 1. `done` then returns to 0 unless a new operation ends at once.
- R7: A start with a loop length of 0 raises `done` for one cycle, starting in the next cycle. No element is issued and `busy` is never raised.
- R8: With a scalar destination, the cycle that issues the first enabled element is the last one. If no predicate bit below the loop length is set, the loop runs for the full length.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. The running sequence and its operands are unchanged.
- R10: A loop length above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation, sampled only while idle |
| rdPlain | input | REG_W | Destination plain register number |
| rdRedir | input | REG_W | Destination redirected index |
| rdVec | input | 1 | Destination is a vector |
| rs1Plain | input | REG_W | Source 1 plain register number |
| rs1Redir | input | REG_W | Source 1 redirected index |
| rs1Vec | input | 1 | Source 1 is a vector |
| rs2Plain | input | REG_W | Source 2 plain register number |
| rs2Redir | input | REG_W | Source 2 redirected index |
| rs2Vec | input | 1 | Source 2 is a vector |
| predMask | input | MAX_VL | Predicate, bit k enables element k |
| vecLen | input | VLW+1 | Requested loop length |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| issueValid | output | 1 | Present element is enabled and issued |
| issueElem | output | CW | Number of the present element |
| issueRd | output | REG_W | Destination register for this element |
| issueRs1 | output | REG_W | Source 1 register for this element |
| issueRs2 | output | REG_W | Source 2 register for this element |

## Verification
The bench targets these cases:
- A destination index of 30 that wraps past the top of the register space. A design that fails to wrap would present out-of-range registers.
- Sparse predicates. If skipped elements do not advance the offset, every later vector index would be shifted.
- A scalar destination, both with an enabled element in the middle of the mask and with an empty mask. One design error stops too early or runs the full length; the other stalls.
- A length of zero and a length above the maximum. Mishandling these would either issue phantom elements or index past the predicate.
- A start strobe carrying different operands that is held high through every busy cycle. A design that accepted it would restart or swap operands in the middle of a loop.

// File: rtl/pred_elem_seq_pkg.sv
package pred_elem_seq_pkg;
  localparam int NUM_OPS = 3;
  localparam int OP_RD = 0;
  localparam int OP_RS1 = 1;
  localparam int OP_RS2 = 2;

  typedef struct packed {
    logic load;  // capture inputs, element counter to 0
    logic step;  // advance to the next element
  } seqStrobe_t;
endpackage

// File: rtl/pred_elem_seq_lane.sv
module pred_elem_seq_lane #(
  parameter int REG_W = 5,
  parameter int CW = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [REG_W-1:0] plainIdx,
  input  logic [REG_W-1:0] redirIdx,
  input  logic             isVec,
  input  logic [CW-1:0]    elemCnt,
  output logic [REG_W-1:0] idx
);
  logic [REG_W-1:0] baseQ;
  logic             vecQ;
  logic [REG_W-1:0] offs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      vecQ  <= 1'b0;
    end else if (load) begin
      baseQ <= isVec ? redirIdx : plainIdx;
      vecQ  <= isVec;
    end
  end

  always_comb begin
    offs = vecQ ? REG_W'(elemCnt) : '0;
    idx  = baseQ + offs;
  end

  // R4
  scalar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !vecQ) |=> $stable(idx));
endmodule

// File: rtl/pred_elem_seq_dp.sv
module pred_elem_seq_dp
  import pred_elem_seq_pkg::*;
#(
  parameter int MAX_VL = 32,
  parameter int REG_W = 5,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int CW = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             busy,
  input  logic [REG_W-1:0] opPlain [NUM_OPS],
  input  logic [REG_W-1:0] opRedir [NUM_OPS],
  input  logic             opVec [NUM_OPS],
  input  logic [MAX_VL-1:0] predIn,
  input  logic [VLW:0]     vlIn,
  output logic             startEmpty,
  output logic             lastElem,
  output logic             issueValid,
  output logic [CW-1:0]    issueElem,
  output logic [REG_W-1:0] issueIdx [NUM_OPS]
);
  logic [MAX_VL-1:0] predQ;
  logic [VLW-1:0]    vlQ;
  logic [VLW-1:0]    vlClamp;
  logic              rdVecQ;
  logic [CW-1:0]     elemCnt;
  logic              curBit;

  always_comb begin
    if (vlIn > (VLW+1)'(MAX_VL)) vlClamp = VLW'(MAX_VL);
    else vlClamp = VLW'(vlIn);
    startEmpty = (vlIn == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predQ   <= '0;
      vlQ     <= '0;
      rdVecQ  <= 1'b0;
      elemCnt <= '0;
    end else if (strobe.load) begin
      predQ   <= predIn;
      vlQ     <= vlClamp;
      rdVecQ  <= opVec[OP_RD];
      elemCnt <= '0;
    end else if (strobe.step) begin
      elemCnt <= elemCnt + 1'b1;
    end
  end

  always_comb begin
    curBit     = predQ[elemCnt];
    lastElem   = ((VLW'(elemCnt) + VLW'(1)) == vlQ) || (!rdVecQ && curBit);
    issueValid = busy && curBit;
    issueElem  = elemCnt;
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : gLane
    pred_elem_seq_lane #(.REG_W(REG_W), .CW(CW)) lane (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobe.load),
      .plainIdx (opPlain[g]),
      .redirIdx (opRedir[g]),
      .isVec    (opVec[g]),
      .elemCnt  (elemCnt),
      .idx      (issueIdx[g])
    );
  end

  // R2
  elem_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> elemCnt == CW'($past(elemCnt) + 1'b1));
  // R6
  elem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (VLW'(elemCnt) < vlQ));
endmodule

// File: rtl/pred_elem_seq_ctrl.sv
module pred_elem_seq_ctrl
  import pred_elem_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       startEmpty,
  input  logic       lastElem,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  logic busyQ;
  logic doneQ;

  always_comb begin
    strobe.load = start && !busyQ;
    strobe.step = busyQ && !lastElem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.load) begin
        if (startEmpty) doneQ <= 1'b1;
        else busyQ <= 1'b1;
      end else if (busyQ && lastElem) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);
  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busyQ && doneQ));
  // R7
  empty_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busyQ && startEmpty) |=> (doneQ && !busyQ));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastElem) |=> busyQ);
endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
  import pred_elem_seq_pkg::*;
#(
  parameter int MAX_VL = 32,
  parameter int REG_W = 5,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int CW = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [REG_W-1:0]  rdPlain,
  input  logic [REG_W-1:0]  rdRedir,
  input  logic              rdVec,
  input  logic [REG_W-1:0]  rs1Plain,
  input  logic [REG_W-1:0]  rs1Redir,
  input  logic              rs1Vec,
  input  logic [REG_W-1:0]  rs2Plain,
  input  logic [REG_W-1:0]  rs2Redir,
  input  logic              rs2Vec,
  input  logic [MAX_VL-1:0] predMask,
  input  logic [VLW:0]      vecLen,
  output logic              busy,
  output logic              done,
  output logic              issueValid,
  output logic [CW-1:0]     issueElem,
  output logic [REG_W-1:0]  issueRd,
  output logic [REG_W-1:0]  issueRs1,
  output logic [REG_W-1:0]  issueRs2
);
  seqStrobe_t       strobe;
  logic             startEmpty;
  logic             lastElem;
  logic [REG_W-1:0] opPlain [NUM_OPS];
  logic [REG_W-1:0] opRedir [NUM_OPS];
  logic             opVec [NUM_OPS];
  logic [REG_W-1:0] issueIdx [NUM_OPS];

  always_comb begin
    opPlain[OP_RD]  = rdPlain;
    opPlain[OP_RS1] = rs1Plain;
    opPlain[OP_RS2] = rs2Plain;
    opRedir[OP_RD]  = rdRedir;
    opRedir[OP_RS1] = rs1Redir;
    opRedir[OP_RS2] = rs2Redir;
    opVec[OP_RD]    = rdVec;
    opVec[OP_RS1]   = rs1Vec;
    opVec[OP_RS2]   = rs2Vec;
  end

  pred_elem_seq_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .startEmpty (startEmpty),
    .lastElem   (lastElem),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  pred_elem_seq_dp #(.MAX_VL(MAX_VL), .REG_W(REG_W)) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busy       (busy),
    .opPlain    (opPlain),
    .opRedir    (opRedir),
    .opVec      (opVec),
    .predIn     (predMask),
    .vlIn       (vecLen),
    .startEmpty (startEmpty),
    .lastElem   (lastElem),
    .issueValid (issueValid),
    .issueElem  (issueElem),
    .issueIdx   (issueIdx)
  );

  assign issueRd  = issueIdx[OP_RD];
  assign issueRs1 = issueIdx[OP_RS1];
  assign issueRs2 = issueIdx[OP_RS2];

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |-> !issueValid);
endmodule

// File: tb/pred_elem_seq_test.sv
module pred_elem_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [4:0] rdPlain = '0, rdRedir = '0, rs1Plain = '0, rs1Redir = '0, rs2Plain = '0, rs2Redir = '0;
  logic rdVec = 1'b0, rs1Vec = 1'b0, rs2Vec = 1'b0;
  logic [31:0] predMask = '0;
  logic [6:0] vecLen = '0;
  logic busy, done, issueValid;
  logic [4:0] issueElem, issueRd, issueRs1, issueRs2;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pred_elem_seq uut (
    .clk(clk), .rstN(rstN), .start(start),
    .rdPlain(rdPlain), .rdRedir(rdRedir), .rdVec(rdVec),
    .rs1Plain(rs1Plain), .rs1Redir(rs1Redir), .rs1Vec(rs1Vec),
    .rs2Plain(rs2Plain), .rs2Redir(rs2Redir), .rs2Vec(rs2Vec),
    .predMask(predMask), .vecLen(vecLen),
    .busy(busy), .done(done), .issueValid(issueValid), .issueElem(issueElem),
    .issueRd(issueRd), .issueRs1(issueRs1), .issueRs2(issueRs2)
  );

  typedef struct packed {
    logic [4:0] rdP; logic [4:0] rdR; logic rdV;
    logic [4:0] s1P; logic [4:0] s1R; logic s1V;
    logic [4:0] s2P; logic [4:0] s2R; logic s2V;
    logic [31:0] pred;
    logic [6:0] vl;
  } caseT;

  localparam int NCASES = 8;
  localparam caseT CASES [NCASES] = '{
    '{5'd3, 5'd10, 1'b1, 5'd4, 5'd20, 1'b1, 5'd5, 5'd24, 1'b1, 32'h0000000F, 7'd4},
    '{5'd1, 5'd8,  1'b1, 5'd6, 5'd17, 1'b0, 5'd7, 5'd12, 1'b1, 32'h00000005, 7'd5},
    '{5'd9, 5'd2,  1'b0, 5'd11,5'd14, 1'b1, 5'd13,5'd16, 1'b0, 32'h00000034, 7'd6},
    '{5'd2, 5'd5,  1'b0, 5'd3, 5'd6,  1'b1, 5'd4, 5'd7,  1'b1, 32'hFFFFFFF8, 7'd3},
    '{5'd1, 5'd2,  1'b1, 5'd3, 5'd4,  1'b1, 5'd5, 5'd6,  1'b1, 32'hFFFFFFFF, 7'd0},
    '{5'd0, 5'd30, 1'b1, 5'd0, 5'd29, 1'b1, 5'd31,5'd1,  1'b0, 32'hFFFFFFFF, 7'd5},
    '{5'd4, 5'd0,  1'b1, 5'd5, 5'd8,  1'b1, 5'd6, 5'd16, 1'b0, 32'hA5A50F0F, 7'd40},
    '{5'd7, 5'd1,  1'b1, 5'd8, 5'd2,  1'b0, 5'd9, 5'd3,  1'b1, 32'h80000001, 7'd32}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic scramble();
    start = 1'b1;
    rdPlain = 5'd17; rdRedir = 5'd27; rdVec = ~rdVec;
    rs1Plain = 5'd19; rs1Redir = 5'd23; rs1Vec = ~rs1Vec;
    rs2Plain = 5'd21; rs2Redir = 5'd25; rs2Vec = ~rs2Vec;
    predMask = ~predMask; vecLen = 7'd0;
  endtask

  task automatic runCase(input caseT c);
    int vlEff;
    int lastK;
    int selRd, selS1, selS2;
    string lenReq;
    vlEff = (c.vl > 7'd32) ? 32 : int'(c.vl);
    lenReq = (c.vl > 7'd32) ? "R10" : "R2";
    lastK = vlEff - 1;
    if (!c.rdV) begin
      for (int k = 0; k < vlEff; k++) if (c.pred[k]) begin lastK = k; break; end
    end
    selRd = c.rdV ? int'(c.rdR) : int'(c.rdP);
    selS1 = c.s1V ? int'(c.s1R) : int'(c.s1P);
    selS2 = c.s2V ? int'(c.s2R) : int'(c.s2P);
    rdPlain = c.rdP; rdRedir = c.rdR; rdVec = c.rdV;
    rs1Plain = c.s1P; rs1Redir = c.s1R; rs1Vec = c.s1V;
    rs2Plain = c.s2P; rs2Redir = c.s2R; rs2Vec = c.s2V;
    predMask = c.pred; vecLen = c.vl; start = 1'b1;
    @(negedge clk);
    if (vlEff == 0) begin
      start = 1'b0;
      chk("R7", "done", int'(done), 1);
      chk("R7", "busy", int'(busy), 0);
      chk("R7", "issueValid", int'(issueValid), 0);
      @(negedge clk);
      chk("R7", "done after", int'(done), 0);
      chk("R7", "busy after", int'(busy), 0);
      return;
    end
    for (int k = 0; k <= lastK; k++) begin
      chk("R6", "busy", int'(busy), 1);
      chk(lenReq, "issueElem", int'(issueElem), k);
      chk("R5", "issueValid", int'(issueValid), int'(c.pred[k]));
      if (c.pred[k]) begin
        chk("R3", "issueRd", int'(issueRd), (selRd + (c.rdV ? k : 0)) % 32);
        chk("R4", "issueRs1", int'(issueRs1), (selS1 + (c.s1V ? k : 0)) % 32);
        chk("R4", "issueRs2", int'(issueRs2), (selS2 + (c.s2V ? k : 0)) % 32);
      end
      scramble();  // R9: start held while busy with different operands
      @(negedge clk);
    end
    start = 1'b0;
    chk(c.rdV ? "R6" : "R8", "busy at end", int'(busy), 0);
    chk(c.rdV ? "R6" : "R8", "done at end", int'(done), 1);
    chk("R6", "issueValid at end", int'(issueValid), 0);
    @(negedge clk);
    chk("R6", "done after", int'(done), 0);
    chk("R9", "busy after", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "issueValid in reset", int'(issueValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    for (int i = 0; i < NCASES; i++) begin
      runCase(CASES[i]);
      @(negedge clk);
    end
    // R7: two zero-length starts back to back each give done
    vecLen = 7'd0; start = 1'b1;
    @(negedge clk);
    chk("R7", "done first", int'(done), 1);
    @(negedge clk);
    start = 1'b0;
    chk("R7", "done second", int'(done), 1);
    chk("R7", "busy second", int'(busy), 0);
    @(negedge clk);
    chk("R7", "done cleared", int'(done), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule